// File: doc/BRIEF.md
# Bus Parity Generator and Checker

This block sits beside the pads of a bus agent that shares one 32-bit wire group between addresses and data, plus a 4-bit command/byte-enable group. It computes even parity over those 36 lines every clock. When the agent drove the bus in a clock, the block drives the matching parity bit in the next clock. The block keeps its parity output enable low at all other times, so the read turnaround on the parity line comes out of the timing with no extra logic.

When the agent receives, the parity bit arrives one clock after the value it covers. The block compares that bit with its own result. If the bus value was marked as a data phase, a mismatch produces a one-clock active-low pulse on the data error output, one clock after the parity bit. If the bus value was marked as an address phase or special-cycle phase, a mismatch pulls the system error line low instead. That line is modelled as an open-drain pull-down enable, and it stays active for a parameterised number of clocks. The comparison runs every cycle. Two enable inputs decide whether each error output is allowed to assert.

Top module: `bus_parity_unit`

## Requirements
- R1: While reset is active and in the first clock after reset, par_oe_o is 0, perr_n_o is 1 and serr_oe_o is 0.
- R2: In the clock after a clock with drive_i=1, par_o equals the XOR of the ad_i and cbe_i values from that earlier clock. This makes the 36 bus bits plus par_o hold an even number of ones.
- R3: par_oe_o is 1 exactly in the clocks that follow a clock with drive_i=1, and 0 otherwise.
- R4: A data error is reported under three conditions: data_chk_i=1 in clock N, par_i in clock N+1 differs from the parity of clock N's bus value, and perr_en_i=1 in clock N+1. When all three hold, perr_n_o is 0 in clock N+2 only.
- R5: When par_i matches the computed parity, neither error output asserts.
- R6: A mismatch on a value qualified by addr_chk_i (address or special cycle) drives serr_oe_o and never perr_n_o.
- R7: A system error event makes serr_oe_o 1 for SERR_HOLD consecutive clocks, starting in clock N+2. The default value of SERR_HOLD is 2.
- R8: perr_en_i=0 or serr_en_i=0 in the parity clock keeps the corresponding error output inactive.
- R9: A mismatch on a bus value with neither qualifier set reports nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ad_i | input | AD_W | Address/data lines as seen this clock |
| cbe_i | input | CBE_W | Command/byte-enable lines as seen this clock |
| drive_i | input | 1 | The agent drives the bus this clock |
| par_i | input | 1 | Received parity line |
| data_chk_i | input | 1 | This clock's bus value is a received data phase |
| addr_chk_i | input | 1 | This clock's bus value is an address or special-cycle phase |
| perr_en_i | input | 1 | Allows data error reporting |
| serr_en_i | input | 1 | Allows system error reporting |
| par_o | output | 1 | Parity value to drive |
| par_oe_o | output | 1 | Parity output enable |
| perr_n_o | output | 1 | Data parity error, active low |
| serr_oe_o | output | 1 | Pull-down enable for the open-drain system error line |

## Verification
The bench sweeps every single-bit bus pattern and a set of pseudo-random values. For each one it tries correct and flipped parity, both enables, and all three qualifier kinds. A design that computed odd parity, or that included the wrong lines, would fail R2 on the single-bit patterns. A design that compared parity in the same clock as the data would flag errors on correct parity. A design that routed address errors to the data error line would fail R6. A design that released the system error line early, or let the data error pulse stretch, would be caught by the clock-by-clock R7 and R4 checks. Unqualified mismatches and disabled enables are observed at the error outputs in the clock where a report would otherwise appear.

// File: rtl/bus_parity_unit.sv
module bus_parity_unit #(
  parameter int AD_W      = 32,
  parameter int CBE_W     = 4,
  parameter int SERR_HOLD = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AD_W-1:0]  ad_i,
  input  logic [CBE_W-1:0] cbe_i,
  input  logic             drive_i,
  input  logic             par_i,
  input  logic             data_chk_i,
  input  logic             addr_chk_i,
  input  logic             perr_en_i,
  input  logic             serr_en_i,
  output logic             par_o,
  output logic             par_oe_o,
  output logic             perr_n_o,
  output logic             serr_oe_o
);
  localparam int HW = $clog2(SERR_HOLD + 1);
  localparam logic [HW-1:0] HOLD_INIT = HW'(SERR_HOLD);

  logic          calc_q, drive_q, dchk_q, achk_q, perr_q;
  logic [HW-1:0] hold_q;
  logic          miss;

  assign miss = par_i ^ calc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q  <= 1'b0;
      drive_q <= 1'b0;
      dchk_q  <= 1'b0;
      achk_q  <= 1'b0;
      perr_q  <= 1'b0;
      hold_q  <= '0;
    end else begin
      calc_q  <= ^{ad_i, cbe_i};
      drive_q <= drive_i;
      dchk_q  <= data_chk_i;
      achk_q  <= addr_chk_i;
      perr_q  <= dchk_q & perr_en_i & miss;
      if (achk_q && serr_en_i && miss) hold_q <= HOLD_INIT;
      else if (hold_q != '0)           hold_q <= hold_q - 1'b1;
    end
  end

  assign par_o     = calc_q;
  assign par_oe_o  = drive_q;
  assign perr_n_o  = ~perr_q;
  assign serr_oe_o = (hold_q != '0);

  AST_PAR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(drive_i) |-> (par_o == ^$past({ad_i, cbe_i}))); // R2
  AST_OE_ONLY_AFTER_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    par_oe_o |-> $past(drive_i)); // R3
  AST_PERR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |=> (perr_n_o || $past(dchk_q))); // R4
  AST_PERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n_o |-> $past(perr_en_i)); // R8
  AST_SERR_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr_oe_o) |-> $past(achk_q && serr_en_i)); // R6
  AST_SERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(serr_oe_o) && SERR_HOLD > 1) |=> serr_oe_o); // R7
endmodule

// File: tb/tb_bus_parity_unit.sv
module tb_bus_parity_unit;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe_i = '0;
  logic        drive_i = 1'b0, par_i = 1'b0, data_chk_i = 1'b0, addr_chk_i = 1'b0;
  logic        perr_en_i = 1'b0, serr_en_i = 1'b0;
  logic        par_o, par_oe_o, perr_n_o, serr_oe_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  bus_parity_unit #(.AD_W(32), .CBE_W(4), .SERR_HOLD(HOLD)) dut (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .cbe_i(cbe_i), .drive_i(drive_i),
    .par_i(par_i), .data_chk_i(data_chk_i), .addr_chk_i(addr_chk_i),
    .perr_en_i(perr_en_i), .serr_en_i(serr_en_i), .par_o(par_o),
    .par_oe_o(par_oe_o), .perr_n_o(perr_n_o), .serr_oe_o(serr_oe_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic even_par(input logic [31:0] a, input logic [3:0] c);
    int ones = 0;
    for (int k = 0; k < 32; k++) ones += int'(a[k]);
    for (int k = 0; k < 4; k++) ones += int'(c[k]);
    return logic'(ones % 2);
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // mode 0: data phase, 1: address/special phase, 2: unqualified
  task automatic run_case(input logic [31:0] a, input logic [3:0] c,
                          input int mode, input logic err, input logic en);
    logic p;
    p = even_par(a, c);
    ad_i = a; cbe_i = c; drive_i = 1'b1;
    data_chk_i = (mode == 0); addr_chk_i = (mode == 1);
    par_i = 1'b0; perr_en_i = 1'b1; serr_en_i = 1'b1;
    step;
    check("R2", par_o, p);
    check("R3", par_oe_o, 1'b1);
    ad_i = ~a; cbe_i = ~c; drive_i = 1'b0; data_chk_i = 1'b0; addr_chk_i = 1'b0;
    par_i = p ^ err; perr_en_i = en; serr_en_i = en;
    step;
    check("R3", par_oe_o, 1'b0);
    if (!err) begin
      check("R5", perr_n_o, 1'b1);
      check("R5", serr_oe_o, 1'b0);
    end else if (mode == 2) begin
      check("R9", perr_n_o, 1'b1);
      check("R9", serr_oe_o, 1'b0);
    end else if (!en) begin
      check("R8", perr_n_o, 1'b1);
      check("R8", serr_oe_o, 1'b0);
    end else if (mode == 0) begin
      check("R4", perr_n_o, 1'b0);
      check("R4", serr_oe_o, 1'b0);
    end else begin
      check("R6", perr_n_o, 1'b1);
      check("R6", serr_oe_o, 1'b1);
    end
    ad_i = '0; cbe_i = '0; par_i = 1'b0; perr_en_i = 1'b1; serr_en_i = 1'b1;
    step;
    check("R4", perr_n_o, 1'b1);
    check("R7", serr_oe_o, (mode == 1) && err && en && HOLD > 1);
    step;
    check("R7", serr_oe_o, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [35:0] lfsr;
    lfsr = 36'h9_A5C3_1E77;
    #3;
    check("R1", par_oe_o, 1'b0);
    check("R1", perr_n_o, 1'b1);
    check("R1", serr_oe_o, 1'b0);
    step; step;
    rst_n = 1'b1;
    step;
    check("R1", par_oe_o, 1'b0);
    check("R1", perr_n_o, 1'b1);
    check("R1", serr_oe_o, 1'b0);
    for (int i = 0; i < 48; i++) begin
      logic [35:0] v;
      if (i < 36) v = 36'd1 << i;
      else begin
        lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]};
        v = lfsr;
      end
      for (int m = 0; m < 3; m++)
        for (int e = 0; e < 2; e++)
          for (int n = 0; n < 2; n++)
            run_case(v[31:0], v[35:32], m, logic'(e), logic'(n));
    end
    run_case(32'hFFFF_FFFF, 4'hF, 0, 1'b1, 1'b1);
    run_case(32'h0, 4'h0, 1, 1'b1, 1'b1);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule